// File: doc/BRIEF.md
# Audio Digital-Silence Zero Detector

The block watches the left and right audio inputs of a converter and raises a zero flag for each channel once that channel has been silent long enough. In sample mode it sees whole samples, one per word-clock period, and a channel counts as silent while every sample it receives is all zero. In one-bit stream mode it gathers the stream into 8-bit groups. A channel then counts as silent while each group obeys a selected bit-pattern rule, and that must last for a time window measured in ticks of a slow time-base strobe.

The two flags drive the status pins and a two-bit status word that software can read. A sample-mode enable gates the flags in sample mode. A 2-bit rule select turns stream-mode flagging off or chooses the rule. Any change to the mode or to either enable restarts detection on both channels.

Top module: `zd_silence_detect`

## Requirements
- R1: After reset both flags are 0 and the status word reads 00.
- R2: In sample mode with the sample enable at 1, a channel's flag rises on the strobe that delivers its PCM_RUN-th consecutive all-zero sample (visible the next cycle), and not earlier.
- R3: In sample mode a strobed non-zero sample clears that channel's run count and flag at once, and its flag stays 0 until PCM_RUN more zero samples arrive.
- R4: With the sample enable at 0 the flags stay 0 in sample mode, whatever samples arrive.
- R5: The two channels are judged independently: the data of one never changes the flag of the other.
- R6: In stream mode, bits are shifted into a group MSB-first (the first bit received is bit 7), and each group is judged on the bit strobe that completes it.
- R7: Rule select 01 accepts a group that holds exactly four ones. Rule select 10 or 11 accepts only the group 1001_0110 (0x96), so a balanced group of any other value breaks the run.
- R8: In stream mode a channel's run starts with its first accepted group. Each time-base tick that comes while the run was already active counts once, and the flag rises with the DSD_TICKS-th counted tick.
- R9: A rejected group clears that channel's tick count, run and flag. If a tick arrives in the same cycle as the rejected group, the rejection wins and the tick is not counted.
- R10: With rule select 00 in stream mode the flags stay 0.
- R11: A change in the mode, the sample enable or the rule select clears both channels' counters, flags and any partly gathered group in the cycle it is seen. Strobes in that cycle are dropped.
- R12: Sample strobes are ignored in stream mode, and bit strobes and ticks are ignored in sample mode.
- R13: Status bit 0 is the left flag and status bit 1 is the right flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dsd_mode | input | 1 | 1 selects one-bit stream mode, 0 selects sample mode |
| pcm_zero_en | input | 1 | Enables the flags in sample mode |
| dsd_rule_sel | input | 2 | Stream rule: 00 off, 01 balanced group, 1x 0x96 pattern |
| smp_stb | input | 1 | One-cycle strobe per word-clock period |
| smp_left | input | SAMPLE_W | Left sample, valid with smp_stb |
| smp_right | input | SAMPLE_W | Right sample, valid with smp_stb |
| bit_stb | input | 1 | One-cycle strobe per stream bit |
| bit_left | input | 1 | Left stream bit, valid with bit_stb |
| bit_right | input | 1 | Right stream bit, valid with bit_stb |
| ms_tick | input | 1 | Time-base strobe used to measure the stream window |
| zero_left | output | 1 | Left silence flag |
| zero_right | output | 1 | Right silence flag |
| zero_status | output | 2 | Status word, bit 0 left flag, bit 1 right flag |

## Verification
In stream mode two events can land in the same cycle: a time-base tick and the bit strobe that completes a group which breaks the rule. The bench builds a channel's tick count to one short of the window and then sends a breaking group with the tick placed on its final bit strobe. The flag must stay low, and one more tick must still leave it low because the count was cleared. A per-clock behavioural model covers every other pairing as well, for example a strobe arriving in the same cycle as a configuration change.

// File: rtl/zd_pkg.sv
// Package: shared types for the silence detector.
// Assumes a 2-bit rule select where any code with bit 1 set picks the pattern rule.
package zd_pkg;

    typedef enum logic [1:0] {
        RULE_OFF = 2'd0,
        RULE_BAL = 2'd1,
        RULE_PAT = 2'd2
    } zd_rule_e;

    // Map the raw select code to a rule.
    function automatic zd_rule_e decode_rule(input logic [1:0] sel);
        if (sel[1])
            return RULE_PAT;
        else if (sel[0])
            return RULE_BAL;
        else
            return RULE_OFF;
    endfunction

endpackage

// File: rtl/zd_cfg_watch.sv
// Module: zd_cfg_watch
// Remembers the configuration seen on the previous clock. It raises a
// restart pulse in any cycle where the configuration differs from that copy.
// Assumes the configuration inputs are synchronous to clk.
module zd_cfg_watch #(
    parameter int CFG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CFG_W-1:0] cfg,
    output logic             restart
);

    logic [CFG_W-1:0] cfg_q;

    // Keep last cycle's configuration; adopt the live value during reset.
    always_ff @(posedge clk) begin
        cfg_q <= cfg;
    end

    // A difference from the stored copy is a configuration change.
    assign restart = rst_n && (cfg != cfg_q);

endmodule

// File: rtl/zd_pcm_run.sv
// Module: zd_pcm_run
// Counts consecutive all-zero samples on one channel and raises a flag
// once PCM_RUN of them have arrived. A non-zero sample restarts the run.
// Assumes one strobe per word-clock period. The count saturates at PCM_RUN.
module zd_pcm_run #(
    parameter int SAMPLE_W = 24,
    parameter int PCM_RUN  = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                restart,
    input  logic                active,
    input  logic                enable,
    input  logic                stb,
    input  logic [SAMPLE_W-1:0] data,
    output logic                flag
);

    localparam int CW = $clog2(PCM_RUN + 1);
    localparam logic [CW-1:0] RUN_MAX  = CW'(PCM_RUN);
    localparam logic [CW-1:0] RUN_LAST = CW'(PCM_RUN - 1);

    logic [CW-1:0] run_cnt;
    logic          flag_q;
    logic          is_zero;

    // Detect an all-zero sample.
    assign is_zero = (data == '0);

    // Advance or restart the zero run on each accepted sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            flag_q  <= 1'b0;
        end else if (restart) begin
            run_cnt <= '0;
            flag_q  <= 1'b0;
        end else if (active && stb) begin
            if (is_zero) begin
                if (run_cnt != RUN_MAX)
                    run_cnt <= run_cnt + 1'b1;
                flag_q <= enable && (run_cnt >= RUN_LAST);
            end else begin
                run_cnt <= '0;
                flag_q  <= 1'b0;
            end
        end
    end

    assign flag = flag_q;

    AST_PCM_DATA_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && stb && !is_zero) |=> (!flag_q && run_cnt == '0)); // R3

    AST_PCM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable) |=> !flag_q); // R4

    AST_PCM_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |-> (run_cnt == RUN_MAX)); // R2

endmodule

// File: rtl/zd_dsd_run.sv
// Module: zd_dsd_run
// Gathers one channel's bit stream MSB-first into groups and judges each
// group on the strobe that completes it. A run starts with an accepted
// group, and the flag rises after DSD_TICKS time-base ticks of unbroken run.
// Assumes GROUP_W >= 2 and that a rejected group outranks a coinciding tick.
module zd_dsd_run
    import zd_pkg::*;
#(
    parameter int          GROUP_W   = 8,
    parameter int          DSD_TICKS = 23,
    parameter logic [GROUP_W-1:0] PATTERN = 8'h96
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart,
    input  logic     active,
    input  zd_rule_e rule,
    input  logic     bit_stb,
    input  logic     bit_in,
    input  logic     tick,
    output logic     flag
);

    localparam int BW = $clog2(GROUP_W);
    localparam int TW = $clog2(DSD_TICKS + 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(GROUP_W - 1);
    localparam logic [BW:0]   HALF     = (BW + 1)'(GROUP_W / 2);
    localparam logic [TW-1:0] TICK_MAX = TW'(DSD_TICKS);
    localparam logic [TW-1:0] TICK_LST = TW'(DSD_TICKS - 1);

    logic [GROUP_W-2:0] shift_q;
    logic [BW-1:0]      nbits_q;
    logic               run_q;
    logic [TW-1:0]      tcnt_q;
    logic               flag_q;

    logic [GROUP_W-1:0] group;
    logic [BW:0]        ones;
    logic               done;
    logic               good;
    logic               bad;

    // Form the candidate group with the newest bit as LSB.
    assign group = {shift_q, bit_in};

    // Count the ones in the candidate group.
    always_comb begin
        ones = '0;
        for (int i = 0; i < GROUP_W; i++)
            ones = ones + {{BW{1'b0}}, group[i]};
    end

    // Judge the group against the selected rule.
    assign done = bit_stb && (nbits_q == LAST_BIT);
    assign good = (rule == RULE_PAT) ? (group == PATTERN) : (ones == HALF);
    assign bad  = done && !good;

    // Shift bits in and count them toward a full group.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            shift_q <= '0;
            nbits_q <= '0;
        end else if (active && bit_stb) begin
            shift_q <= group[GROUP_W-2:0];
            nbits_q <= done ? '0 : nbits_q + 1'b1;
        end
    end

    // Track the run, count window ticks and raise the flag.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            run_q  <= 1'b0;
            tcnt_q <= '0;
            flag_q <= 1'b0;
        end else if (active) begin
            if (bad) begin
                run_q  <= 1'b0;
                tcnt_q <= '0;
                flag_q <= 1'b0;
            end else begin
                if (done)
                    run_q <= 1'b1;
                if (tick && run_q) begin
                    if (tcnt_q != TICK_MAX)
                        tcnt_q <= tcnt_q + 1'b1;
                    if (tcnt_q >= TICK_LST)
                        flag_q <= 1'b1;
                end
            end
        end
    end

    assign flag = flag_q;

    AST_DSD_BAD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bad && !restart) |=> (!flag_q && tcnt_q == '0 && !run_q)); // R9

    AST_DSD_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q |-> (tcnt_q == TICK_MAX && run_q)); // R8

    AST_DSD_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !restart) |=> (tcnt_q == $past(tcnt_q))); // R8

endmodule

// File: rtl/zd_silence_detect.sv
// Module: zd_silence_detect (top)
// Two-channel silence detector with a sample mode and a one-bit stream mode.
// Per channel, a sample-run unit and a stream-run unit are built. The live
// mode picks which one drives the flag. A configuration change restarts both.
// Assumes all strobes are single-cycle and synchronous to clk.
module zd_silence_detect
    import zd_pkg::*;
#(
    parameter int SAMPLE_W  = 24,
    parameter int PCM_RUN   = 1024,
    parameter int DSD_TICKS = 23,
    parameter int GROUP_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dsd_mode,
    input  logic                pcm_zero_en,
    input  logic [1:0]          dsd_rule_sel,
    input  logic                smp_stb,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                bit_stb,
    input  logic                bit_left,
    input  logic                bit_right,
    input  logic                ms_tick,
    output logic                zero_left,
    output logic                zero_right,
    output logic [1:0]          zero_status
);

    localparam int NCH   = 2;
    localparam int CFG_W = 4;

    zd_rule_e            rule;
    logic                restart;
    logic                pcm_active;
    logic                dsd_active;
    logic [SAMPLE_W-1:0] smp_ch [NCH];
    logic [NCH-1:0]      bit_ch;
    logic [NCH-1:0]      pcm_flag;
    logic [NCH-1:0]      dsd_flag;
    logic [NCH-1:0]      flag_ch;

    // Decode the rule and qualify each mode's unit.
    assign rule       = decode_rule(dsd_rule_sel);
    assign pcm_active = !dsd_mode;
    assign dsd_active = dsd_mode && (rule != RULE_OFF);

    // Index the channel inputs: 0 left, 1 right.
    assign smp_ch[0] = smp_left;
    assign smp_ch[1] = smp_right;
    assign bit_ch    = {bit_right, bit_left};

    zd_cfg_watch #(.CFG_W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg     ({dsd_mode, pcm_zero_en, dsd_rule_sel}),
        .restart (restart)
    );

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        zd_pcm_run #(.SAMPLE_W(SAMPLE_W), .PCM_RUN(PCM_RUN)) u_pcm (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .active  (pcm_active),
            .enable  (pcm_zero_en),
            .stb     (smp_stb),
            .data    (smp_ch[ch]),
            .flag    (pcm_flag[ch])
        );

        zd_dsd_run #(.GROUP_W(GROUP_W), .DSD_TICKS(DSD_TICKS),
                     .PATTERN(GROUP_W'(8'h96))) u_dsd (
            .clk     (clk),
            .rst_n   (rst_n),
            .restart (restart),
            .active  (dsd_active),
            .rule    (rule),
            .bit_stb (bit_stb),
            .bit_in  (bit_ch[ch]),
            .tick    (ms_tick),
            .flag    (dsd_flag[ch])
        );

        // Pick the unit of the live mode.
        assign flag_ch[ch] = dsd_mode ? dsd_flag[ch] : pcm_flag[ch];
    end

    assign zero_left   = flag_ch[0];
    assign zero_right  = flag_ch[1];
    assign zero_status = flag_ch;

    AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (!zero_left && !zero_right)); // R11

    AST_DSD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (dsd_mode && dsd_rule_sel == 2'b00) |=> (zero_status == 2'b00)); // R10

    AST_PCM_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dsd_mode && !smp_stb && !restart) |=> $stable(zero_status)); // R12

endmodule

// File: tb/zd_silence_detect_bench.sv
// Bench: drives inputs on falling edges and runs a behavioural reference
// model on rising edges. The model is compared with the outputs every clock,
// and directed checks sample at falling edges.
module zd_silence_detect_bench;

    localparam int SW = 8;
    localparam int RUN = 16;
    localparam int TK = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dsd_mode = 1'b0, pcm_zero_en = 1'b1;
    logic [1:0] dsd_rule_sel = 2'b00;
    logic smp_stb = 1'b0, bit_stb = 1'b0, bit_left = 1'b0, bit_right = 1'b0, ms_tick = 1'b0;
    logic [SW-1:0] smp_left = '0, smp_right = '0;
    logic zero_left, zero_right;
    logic [1:0] zero_status;

    int checks = 0;
    int fails = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    zd_silence_detect #(.SAMPLE_W(SW), .PCM_RUN(RUN), .DSD_TICKS(TK), .GROUP_W(8)) u_zd_silence_detect (
        .clk(clk), .rst_n(rst_n), .dsd_mode(dsd_mode), .pcm_zero_en(pcm_zero_en),
        .dsd_rule_sel(dsd_rule_sel), .smp_stb(smp_stb), .smp_left(smp_left),
        .smp_right(smp_right), .bit_stb(bit_stb), .bit_left(bit_left),
        .bit_right(bit_right), .ms_tick(ms_tick), .zero_left(zero_left),
        .zero_right(zero_right), .zero_status(zero_status)
    );

    // Reference model state, per channel.
    int m_pcnt [2];
    int m_sr [2];
    int m_nb [2];
    int m_tc [2];
    bit m_run [2];
    bit m_flag [2];
    bit m_pflag [2];
    int m_cfg;

    function automatic int popc(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return n;
    endfunction

    task automatic model_clear();
        for (int c = 0; c < 2; c++) begin
            m_pcnt[c] = 0; m_sr[c] = 0; m_nb[c] = 0; m_tc[c] = 0;
            m_run[c] = 0; m_flag[c] = 0; m_pflag[c] = 0;
        end
    endtask

    // Compare outputs with the model, then advance the model one clock.
    always @(posedge clk) begin
        int cfg_now;
        bit bad, run_before, b;
        int s;
        cfg_now = {dsd_mode, pcm_zero_en, dsd_rule_sel};
        if (!rst_n) begin
            model_clear();
            m_cfg = cfg_now;
        end else begin
            checks++;
            if (zero_status !== {m_flag[1], m_flag[0]} || zero_left !== m_flag[0] || zero_right !== m_flag[1]) begin
                fails++;
                $display("FAIL %s model compare: actual %b expected %b", phase, zero_status, {m_flag[1], m_flag[0]});
            end
            if (cfg_now != m_cfg) begin
                model_clear();
                m_cfg = cfg_now;
            end else if (!dsd_mode) begin
                if (smp_stb) begin
                    for (int c = 0; c < 2; c++) begin
                        s = (c == 0) ? int'(smp_left) : int'(smp_right);
                        if (s == 0) begin
                            if (m_pcnt[c] < RUN) m_pcnt[c]++;
                            m_flag[c] = pcm_zero_en && (m_pcnt[c] >= RUN);
                        end else begin
                            m_pcnt[c] = 0; m_flag[c] = 0;
                        end
                    end
                end
            end else if (dsd_rule_sel != 2'b00) begin
                for (int c = 0; c < 2; c++) begin
                    bad = 0;
                    run_before = m_run[c];
                    b = (c == 0) ? bit_left : bit_right;
                    if (bit_stb) begin
                        m_sr[c] = ((m_sr[c] << 1) | int'(b)) & 255;
                        m_nb[c]++;
                        if (m_nb[c] == 8) begin
                            m_nb[c] = 0;
                            if (dsd_rule_sel[1] ? (m_sr[c] == 'h96) : (popc(m_sr[c]) == 4))
                                m_run[c] = 1;
                            else begin
                                bad = 1; m_run[c] = 0; m_tc[c] = 0; m_flag[c] = 0;
                            end
                        end
                    end
                    if (!bad && ms_tick && run_before) begin
                        if (m_tc[c] < TK) m_tc[c]++;
                        if (m_tc[c] >= TK) m_flag[c] = 1;
                    end
                end
            end
        end
    end

    task automatic chk(input string tag, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic sample(input logic [SW-1:0] l, input logic [SW-1:0] r);
        @(negedge clk);
        smp_left = l; smp_right = r; smp_stb = 1'b1;
        @(negedge clk);
        smp_stb = 1'b0;
    endtask

    task automatic send_bit(input logic l, input logic r, input logic tk);
        @(negedge clk);
        bit_left = l; bit_right = r; bit_stb = 1'b1; ms_tick = tk;
        @(negedge clk);
        bit_stb = 1'b0; ms_tick = 1'b0;
    endtask

    task automatic group(input logic [7:0] l, input logic [7:0] r, input logic tick_last);
        for (int i = 7; i >= 0; i--) send_bit(l[i], r[i], (i == 0) ? tick_last : 1'b0);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1'b1;
            @(negedge clk); ms_tick = 1'b0;
        end
    endtask

    task automatic set_cfg(input logic m, input logic pe, input logic [1:0] sel);
        @(negedge clk);
        dsd_mode = m; pcm_zero_en = pe; dsd_rule_sel = sel;
        idle(2);
    endtask

    initial begin
        idle(3);
        chk("R1 reset status", zero_status, 2'b00);
        rst_n = 1'b1;
        idle(2);
        chk("R1 after release", {zero_right, zero_left}, 2'b00);

        phase = "R2";
        for (int i = 0; i < RUN - 1; i++) sample('0, '0);
        chk("R2 one sample short", zero_status, 2'b00);
        sample('0, '0);
        chk("R2 run complete", zero_status, 2'b11);
        chk("R13 both flags", {zero_right, zero_left}, 2'b11);

        phase = "R3";
        sample(8'h01, '0);
        chk("R3 left cleared, R5 right kept", zero_status, 2'b10);
        chk("R13 right is bit1", {1'b0, zero_right}, 2'b01);
        for (int i = 0; i < RUN - 1; i++) sample('0, '0);
        chk("R3 left not yet back", zero_status, 2'b10);
        sample('0, '0);
        chk("R3 left back", zero_status, 2'b11);

        phase = "R12";
        group(8'h07, 8'h07, 1'b1);
        tick(3);
        chk("R12 stream inputs ignored in sample mode", zero_status, 2'b11);

        phase = "R11";
        set_cfg(1'b0, 1'b0, 2'b00);
        chk("R11 enable change clears", zero_status, 2'b00);
        phase = "R4";
        for (int i = 0; i < RUN + 4; i++) sample('0, '0);
        chk("R4 gated off", zero_status, 2'b00);

        phase = "R8";
        set_cfg(1'b1, 1'b1, 2'b01);
        group(8'h55, 8'h0F, 1'b0);
        for (int i = 0; i < TK - 1; i++) begin
            tick(1);
            group(8'hA5, 8'h3C, 1'b0);
        end
        chk("R8 one tick short", zero_status, 2'b00);
        tick(1);
        chk("R8 window reached, R6 balanced", zero_status, 2'b11);

        phase = "R12";
        sample(8'h7F, 8'h7F);
        chk("R12 sample strobe ignored in stream mode", zero_status, 2'b11);

        phase = "R9";
        group(8'h07, 8'h33, 1'b0);
        chk("R9 left rejected, R5 right kept", zero_status, 2'b10);
        group(8'h99, 8'h66, 1'b0);
        tick(TK - 1);
        chk("R9 left short of window", zero_status, 2'b10);
        group(8'hFE, 8'h0F, 1'b1);
        chk("R9 reject beats coinciding tick", zero_status, 2'b10);
        tick(1);
        chk("R9 count was cleared", zero_status, 2'b10);

        phase = "R7";
        set_cfg(1'b1, 1'b1, 2'b10);
        chk("R11 rule change clears", zero_status, 2'b00);
        group(8'h96, 8'h96, 1'b0);
        tick(TK);
        chk("R7 pattern accepted", zero_status, 2'b11);
        group(8'h69, 8'h96, 1'b0);
        chk("R6 reversed order rejected", zero_status, 2'b10);
        group(8'h96, 8'h55, 1'b0);
        chk("R7 balanced non-pattern rejected", zero_status, 2'b00);

        phase = "R11";
        set_cfg(1'b1, 1'b1, 2'b01);
        send_bit(1'b1, 1'b1, 1'b0);
        send_bit(1'b1, 1'b1, 1'b0);
        send_bit(1'b1, 1'b1, 1'b0);
        set_cfg(1'b1, 1'b1, 2'b11);
        group(8'h96, 8'h96, 1'b0);
        tick(TK);
        chk("R11 partial group discarded", zero_status, 2'b11);

        phase = "R10";
        set_cfg(1'b1, 1'b1, 2'b00);
        group(8'h96, 8'h55, 1'b0);
        tick(TK + 3);
        group(8'h96, 8'h55, 1'b0);
        tick(2);
        chk("R10 rule off", zero_status, 2'b00);

        idle(4);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule